// File: doc/BRIEF.md
# Asymmetric Sleep-Signal Deglitch Filter

This block cleans up an active-low sleep-state line driven by a host. The raw line is sampled once on each cycle where the evaluation enable is high. A free-running millisecond counter supplies time stamps. The two directions are filtered by different rules. The filtered flag leaves the asserted (sleeping) state only after the line has stayed high for a minimum number of milliseconds. This time is measured as a wrapping difference between time stamps. The flag returns to asserted after a small number of consecutive low samples. Because one short low pulse is enough to hold the flag asserted, the filter favours the asserted state.

The state is one deasserted bit and a shared stamp-wide field. In the asserted state the field holds the time stamp of the most recent low sample. In the deasserted state it holds the current run of low samples. A dedicated initialise input, and the synchronous reset, force the asserted state and load the present counter value as the stamp.

Top module: `sleep_deglitch`

## Requirements
- R1: While `rst` is high, the state becomes asserted (`sleep_active` = 1) on each clock edge, and the present `ms_now` is stored as the stamp.
- R2: A clock edge with `init_req` high forces the asserted state and stores `ms_now` as the stamp, whatever `eval_en` and the prior state are. A later deassertion is timed from that stamp.
- R3: In the asserted state, an evaluated low sample (`sleep_n_raw` = 0) keeps the flag asserted and replaces the stamp with `ms_now`.
- R4: In the asserted state, an evaluated high sample deasserts the flag when (`ms_now` − stamp) mod 2^STAMP_W ≥ DEASSERT_MS. With the default of 2, a difference of 1 keeps the flag asserted, including across the counter wrap from 127 to 0.
- R5: In the deasserted state, ASSERT_CNT consecutive evaluated low samples (default 2) assert the flag on the edge that takes the last of them.
- R6: In the deasserted state, an evaluated high sample clears the low-sample run, so a low, high, low pattern does not assert the flag.
- R7: On an edge where `eval_en` and `init_req` are both low, the state does not change, and neither `sleep_n_raw` nor `ms_now` affects it.
- R8: A count-based assertion stores `ms_now` of that edge as the stamp, so the next deassertion is timed from it.
- R9: `sleep_active` follows from registered state alone. It changes on the same clock edge that takes the deciding sample, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the initialised state |
| eval_en | input | 1 | Takes one sample of the raw line on this edge |
| init_req | input | 1 | Forces the asserted state and captures the stamp |
| sleep_n_raw | input | 1 | Raw active-low sleep line from the host |
| ms_now | input | STAMP_W (7) | Free-running millisecond count |
| sleep_active | output | 1 | Filtered flag, 1 = sleep asserted |

## Verification
Two situations are the hardest to reach from the ports. The first is a deassertion whose timing window spans the wrap of the 7-bit counter. The second is proof that a stamp was replaced rather than left alone. The bench drives `ms_now` directly instead of letting it run freely. It places an initialise at 126, a low sample at 127, and high samples at 0 and 1, so the wrapped difference decides the result. The stamp replacement is made visible by sampling high at a time that would already have expired against the older stamp, and checking that the flag stays asserted.

// File: rtl/sleep_dg_pkg.sv
package sleep_dg_pkg;

    // Width of the millisecond stamp and of the shared state field.
    localparam int STAMP_W = 7;

    typedef logic [STAMP_W-1:0] stamp_t;

    // One flag bit plus a field whose meaning depends on the flag:
    // a time stamp when asserted, a low-sample run when deasserted.
    typedef struct packed {
        logic   deasserted;
        stamp_t field;
    } dg_state_t;

    // Wrapping age of a stamp relative to the current count.
    function automatic stamp_t stamp_age(input stamp_t now_v, input stamp_t then_v);
        return stamp_t'(now_v - then_v);
    endfunction

    // Builders for the two kinds of state word.
    function automatic dg_state_t mk_asserted(input stamp_t ts);
        dg_state_t s;
        s.deasserted = 1'b0;
        s.field      = ts;
        return s;
    endfunction

    function automatic dg_state_t mk_deasserted(input stamp_t run);
        dg_state_t s;
        s.deasserted = 1'b1;
        s.field      = run;
        return s;
    endfunction

endpackage

// File: rtl/dg_age_check.sv
module dg_age_check
    import sleep_dg_pkg::*;
#(
    parameter int LIMIT = 2
) (
    input  stamp_t now_v,
    input  stamp_t stamp_v,
    output logic   expired
);
    localparam stamp_t LIMIT_W = stamp_t'(LIMIT);

    stamp_t age;

    always_comb begin
        age     = stamp_age(now_v, stamp_v);
        expired = (age >= LIMIT_W);
    end
endmodule

// File: rtl/dg_low_run.sv
module dg_low_run
    import sleep_dg_pkg::*;
#(
    parameter int TARGET = 2
) (
    input  stamp_t run_v,
    output stamp_t run_next,
    output logic   reached
);
    localparam stamp_t TARGET_W = stamp_t'(TARGET);

    always_comb begin
        run_next = run_v + stamp_t'(1);
        reached  = (run_next >= TARGET_W);
    end
endmodule

// File: rtl/sleep_deglitch.sv
module sleep_deglitch
    import sleep_dg_pkg::*;
#(
    parameter int DEASSERT_MS = 2,
    parameter int ASSERT_CNT  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eval_en,
    input  logic               init_req,
    input  logic               sleep_n_raw,
    input  logic [STAMP_W-1:0] ms_now,
    output logic               sleep_active
);
    localparam int     RUN_MAX   = (1 << STAMP_W) - 1;
    localparam stamp_t ASSERT_CW = stamp_t'(ASSERT_CNT);

    // Elaboration guards: a 1 ms window cannot filter a sample that
    // lands just before a counter tick, and the run must fit the field.
    generate
        if (DEASSERT_MS < 2) begin : g_bad_window
            $error("sleep_deglitch: DEASSERT_MS must exceed 1");
        end
        if (ASSERT_CNT < 1 || ASSERT_CNT > RUN_MAX) begin : g_bad_count
            $error("sleep_deglitch: ASSERT_CNT out of range");
        end
    endgenerate

    dg_state_t st_q, st_d;
    logic      age_expired;
    stamp_t    run_next;
    logic      run_reached;

    dg_age_check #(.LIMIT(DEASSERT_MS)) u_age (
        .now_v   (ms_now),
        .stamp_v (st_q.field),
        .expired (age_expired)
    );

    dg_low_run #(.TARGET(ASSERT_CNT)) u_run (
        .run_v    (st_q.field),
        .run_next (run_next),
        .reached  (run_reached)
    );

    always_comb begin
        st_d = st_q;
        if (init_req) begin
            st_d = mk_asserted(ms_now);
        end else if (eval_en) begin
            if (!st_q.deasserted) begin
                if (!sleep_n_raw) begin
                    st_d = mk_asserted(ms_now);
                end else if (age_expired) begin
                    st_d = mk_deasserted('0);
                end
            end else begin
                if (sleep_n_raw) begin
                    st_d = mk_deasserted('0);
                end else if (run_reached) begin
                    st_d = mk_asserted(ms_now);
                end else begin
                    st_d = mk_deasserted(run_next);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= mk_asserted(ms_now);
        end else begin
            st_q <= st_d;
        end
    end

    assign sleep_active = ~st_q.deasserted;

    // R2: an initialise always leaves the flag asserted.
    a_r2_init_asserts: assert property (@(posedge clk) disable iff (rst)
        init_req |=> sleep_active);

    // R3: a low sample taken while asserted never deasserts.
    a_r3_low_holds: assert property (@(posedge clk) disable iff (rst)
        (sleep_active && eval_en && !sleep_n_raw) |=> sleep_active);

    // R4: a fall needs an evaluated high sample without initialise.
    a_r4_fall_on_high: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_active) |-> $past(sleep_n_raw && eval_en && !init_req));

    // R5: a rise outside reset or initialise needs an evaluated low sample.
    a_r5_rise_on_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(sleep_active) && !$past(rst) && !$past(init_req))
            |-> $past(eval_en && !sleep_n_raw));

    // R6: the low run never reaches the target while deasserted.
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
        st_q.deasserted |-> (st_q.field < ASSERT_CW));

    // R7: no evaluation and no initialise keeps the state.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!eval_en && !init_req) |=> $stable(st_q));

endmodule

// File: tb/sim_sleep_deglitch.sv
module sim_sleep_deglitch;
    import sleep_dg_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eval_en = 1'b0;
    logic       init_req = 1'b0;
    logic       sleep_n_raw = 1'b1;
    logic [6:0] ms_now = 7'd0;
    logic       sleep_active;

    always #2.5 clk = ~clk;   // 200 MHz

    sleep_deglitch u0 (
        .clk          (clk),
        .rst          (rst),
        .eval_en      (eval_en),
        .init_req     (init_req),
        .sleep_n_raw  (sleep_n_raw),
        .ms_now       (ms_now),
        .sleep_active (sleep_active)
    );

    typedef struct {
        logic  exp_v;
        string tag;
    } item_t;

    item_t q[$];
    item_t cur;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;

    // Driver: set inputs away from the edge and queue the flag expected after it.
    task automatic step(input logic r, input logic ev, input logic in,
                        input logic sn, input logic [6:0] ms,
                        input logic e, input string tag);
        @(negedge clk);
        rst = r; eval_en = ev; init_req = in; sleep_n_raw = sn; ms_now = ms;
        q.push_back('{e, tag});
    endtask

    // Monitor: compare one item per clock, shortly after the edge.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            cur = q.pop_front();
            n_cmp++;
            if (sleep_active !== cur.exp_v) begin
                n_bad++;
                $display("FAIL %s: sleep_active=%0b expected=%0b", cur.tag, sleep_active, cur.exp_v);
            end
        end
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            report();
        end
    end

    initial begin
        // R1: reset state, stamp 5
        step(1, 0, 0, 1, 7'd5, 1'b1, "R1 reset");
        step(1, 1, 0, 1, 7'd5, 1'b1, "R1 reset held");
        // R4: boundary of the window, stamp 5
        step(0, 1, 0, 1, 7'd6, 1'b1, "R4 age 1 holds");
        step(0, 1, 0, 1, 7'd7, 1'b0, "R4 age 2 deasserts");
        // R6 and R5
        step(0, 1, 0, 0, 7'd8, 1'b0, "R6 first low");
        step(0, 1, 0, 1, 7'd9, 1'b0, "R6 high clears run");
        step(0, 1, 0, 0, 7'd10, 1'b0, "R6 low after clear");
        step(0, 1, 0, 0, 7'd11, 1'b1, "R5 second low asserts");
        // R8: stamp reloaded at 11
        step(0, 1, 0, 1, 7'd12, 1'b1, "R8 age 1 holds");
        step(0, 1, 0, 1, 7'd13, 1'b0, "R8 deassert from new stamp");
        // R7: lows without evaluation do nothing
        step(0, 0, 0, 0, 7'd14, 1'b0, "R7 idle low");
        step(0, 0, 0, 0, 7'd15, 1'b0, "R7 idle low");
        step(0, 0, 0, 0, 7'd16, 1'b0, "R7 idle low");
        step(0, 1, 0, 0, 7'd17, 1'b0, "R7 run not advanced");
        step(0, 1, 0, 0, 7'd18, 1'b1, "R9 assert on deciding edge");
        // R3: stamp 18, refresh at 20
        step(0, 1, 0, 1, 7'd19, 1'b1, "R3 age 1");
        step(0, 1, 0, 0, 7'd20, 1'b1, "R3 low refresh");
        step(0, 1, 0, 1, 7'd21, 1'b1, "R3 old stamp would expire");
        step(0, 1, 0, 1, 7'd22, 1'b0, "R3 new stamp expires");
        // R2: initialise from deasserted
        step(0, 1, 1, 1, 7'd30, 1'b1, "R2 init asserts");
        step(0, 1, 0, 1, 7'd31, 1'b1, "R2 age 1");
        step(0, 1, 0, 1, 7'd32, 1'b0, "R2 timed from init stamp");
        step(0, 0, 1, 1, 7'd40, 1'b1, "R2 init without eval");
        step(0, 0, 0, 1, 7'd41, 1'b1, "R7 idle high holds");
        step(0, 1, 0, 1, 7'd41, 1'b1, "R2 age 1 after init");
        step(0, 1, 0, 1, 7'd42, 1'b0, "R2 deassert after init");
        // R4: wrap of the counter
        step(0, 1, 1, 0, 7'd126, 1'b1, "R4 init at 126");
        step(0, 1, 0, 0, 7'd127, 1'b1, "R4 low at 127");
        step(0, 1, 0, 1, 7'd0, 1'b1, "R4 wrap age 1");
        step(0, 1, 0, 1, 7'd1, 1'b0, "R4 wrap age 2");
        // R1: reset mid-run from deasserted
        step(1, 1, 0, 1, 7'd60, 1'b1, "R1 reset from deasserted");
        step(0, 1, 0, 1, 7'd61, 1'b1, "R1 age 1 after reset");
        step(0, 1, 0, 1, 7'd62, 1'b0, "R1 timed from reset stamp");
        step(0, 0, 0, 1, 7'd62, 1'b0, "R9 settled");
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1;
        report();
    end
endmodule